// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock

This block keeps the time of day and a Gregorian calendar as packed BCD words and advances them once for every pulse on a one-second tick input. It covers 24-hour operation from 1900-01-01 00:00:00 to 2099-12-31 23:59:59, including months of different lengths and the leap-year rule with its century exception. Software reaches it through a plain 32-bit register port with a write strobe and a combinational read path.

To set the clock, software raises one or both update-request bits in the control register. All counting stops, and the next tick sets an acknowledge flag in the status register. Software then writes the time word, the calendar word or both, and clears the request bits. Counting resumes from the written values. Each accepted write is checked in hardware, and a validity register records whether the last programmed time or calendar held an illegal value. A status flag, also driven out on a pin, marks each one-second event. Both status flags are cleared by writing one to the matching bit of a clear register.

Top module: `bcd_rtc_top`

## Requirements
- R1: After reset the time word reads 0x00000000 (00:00:00), the calendar word reads 0x01210019 (1900-01-01, weekday 1), and control, status, validity and the event pin read zero.
- R2: When no update request is active, each tick adds one second. The time word holds BCD seconds in bits 6:0, minutes in bits 14:8 and hours in bits 21:16. Seconds and minutes roll from 59 to 00 with a carry, and hours roll from 23 to 00 with a carry into the date.
- R3: The day of month (calendar bits 29:24, BCD) rolls over to 01 after day 30 in April, June, September and November, and after day 31 in the other months except February. February has 29 days when the year is divisible by 4, except in a century year not divisible by 400 (1900 has 28 days, 2000 has 29).
- R4: The day of week (calendar bits 23:21, binary 1 to 7) steps by one on every day rollover and wraps from 7 to 1.
- R5: The month (bits 20:16, BCD) rolls from 12 to 01 with a carry into the year (bits 15:8, BCD). The year rolls from 99 to 00 with a carry into the century (bits 6:0, BCD 19 or 20). 2099-12-31 23:59:59 is followed by 1900-01-01 00:00:00.
- R6: While either control bit 0 (time update) or control bit 1 (calendar update) is set, ticks advance neither the time nor the calendar.
- R7: Status bit 0 (update acknowledge) is set on the first tick after the control request bits go from none set to any set. A write to the status-clear register (offset 0x1C) with bit 0 set clears it.
- R8: Status bit 2 and the secEvent output are set on every tick. They are cleared by writing 1 to bit 2 at offset 0x1C. A write there with that bit at 0 leaves them set.
- R9: A write to the time word (offset 0x08) takes effect only while control bit 0 is set. A write to the calendar word (offset 0x0C) takes effect only while control bit 1 is set. Other writes to them are ignored.
- R10: Each accepted time write sets or clears validity bit 0 (offset 0x2C). The bit is set if any BCD digit exceeds 9, the seconds or minutes exceed 59, or the hours exceed 23. Each accepted calendar write does the same for validity bit 1, which is set for any of: a digit above 9, a century other than 19 or 20, a month outside 1 to 12, a weekday outside 1 to 7, or a day of month outside 1 to the length of that month and year.
- R11: The mode register (offset 0x04) always reads zero, which means 24-hour operation; writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickSec | input | 1 | One-cycle pulse once per second |
| regAddr | input | ADDR_W | Byte offset of the register accessed |
| regWr | input | 1 | Write strobe for regWdata at regAddr |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Combinational read data for regAddr |
| secEvent | output | 1 | Copy of the one-second status flag |

## Verification
The bench loads dates just before every kind of rollover: a 30-day and a 31-day month end, February in 1900, 2000 and 1904, a year end, a century change and the 2099 wrap. A wrong leap rule or month table would show up as a missing or extra February 29, or as a day 31 in April. It checks that a tick taken during an update request leaves the time unchanged, and that the acknowledge flag waits for a tick instead of rising at once. It also checks that a write made without the matching request bit does not change the words. Illegal nibbles and out-of-range fields confirm that the validity bits follow each write and clear again when a legal value is written.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_MODE  = 8'h04;
  localparam logic [7:0] OFS_TIME  = 8'h08;
  localparam logic [7:0] OFS_CAL   = 8'h0C;
  localparam logic [7:0] OFS_STAT  = 8'h18;
  localparam logic [7:0] OFS_SCLR  = 8'h1C;
  localparam logic [7:0] OFS_VALID = 8'h2C;

  localparam logic [31:0] TIME_MASK  = 32'h003F7F7F;
  localparam logic [31:0] CAL_MASK   = 32'h3FFFFF7F;
  localparam logic [31:0] TIME_RESET = 32'h00000000;
  localparam logic [31:0] CAL_RESET  = 32'h01210019;

  typedef struct packed {
    logic        advance;
    logic        wrTime;
    logic        wrCal;
    logic [31:0] wdata;
  } dpStrobe_t;

  function automatic logic [7:0] bcdToBin(logic [7:0] b);
    return 8'(b[7:4]) * 8'd10 + 8'(b[3:0]);
  endfunction

  function automatic logic [7:0] binToBcd(logic [7:0] v);
    logic [7:0] hi;
    logic [7:0] lo;
    hi = v / 8'd10;
    lo = v % 8'd10;
    return {hi[3:0], lo[3:0]};
  endfunction

  function automatic logic isLeap(logic [7:0] yr, logic [7:0] cen);
    return (yr[1:0] == 2'd0) && ((yr != 8'd0) || (cen[1:0] == 2'd0));
  endfunction

  function automatic logic [7:0] lastDay(logic [7:0] mon, logic [7:0] yr, logic [7:0] cen);
    case (mon)
      8'd2:                      return isLeap(yr, cen) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
      default:                   return 8'd31;
    endcase
  endfunction

  function automatic logic timeLegal(logic [31:0] w);
    logic ok;
    ok = (w[3:0] <= 4'd9) && (w[11:8] <= 4'd9) && (w[19:16] <= 4'd9);
    ok = ok && (bcdToBin({1'b0, w[6:0]}) <= 8'd59);
    ok = ok && (bcdToBin({1'b0, w[14:8]}) <= 8'd59);
    ok = ok && (bcdToBin({2'b0, w[21:16]}) <= 8'd23);
    return ok;
  endfunction

  function automatic logic calLegal(logic [31:0] w);
    logic       ok;
    logic [7:0] cen;
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] day;
    ok  = (w[3:0] <= 4'd9) && (w[11:8] <= 4'd9) && (w[15:12] <= 4'd9);
    ok  = ok && (w[19:16] <= 4'd9) && (w[27:24] <= 4'd9);
    cen = bcdToBin({1'b0, w[6:0]});
    yr  = bcdToBin(w[15:8]);
    mon = bcdToBin({3'b0, w[20:16]});
    day = bcdToBin({2'b0, w[29:24]});
    ok  = ok && ((cen == 8'd19) || (cen == 8'd20));
    ok  = ok && (mon >= 8'd1) && (mon <= 8'd12);
    ok  = ok && (w[23:21] != 3'd0);
    ok  = ok && (day >= 8'd1) && (day <= lastDay(mon, yr, cen));
    return ok;
  endfunction

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickSec,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [31:0]       regWdata,
  input  logic [31:0]       timeWord,
  input  logic [31:0]       calWord,
  input  logic [1:0]        validBits,
  output dpStrobe_t         dpStb,
  output logic [31:0]       regRdata,
  output logic [1:0]        ctrlBits,
  output logic              ackFlag,
  output logic              secFlag
);

  logic ackPend;
  logic selCtrl, selTime, selCal, selSclr;
  logic anyReq;

  assign selCtrl = (regAddr == ADDR_W'(OFS_CTRL));
  assign selTime = (regAddr == ADDR_W'(OFS_TIME));
  assign selCal  = (regAddr == ADDR_W'(OFS_CAL));
  assign selSclr = (regAddr == ADDR_W'(OFS_SCLR));
  assign anyReq  = (ctrlBits != 2'b00);

  always_comb begin
    dpStb.advance = tickSec && !anyReq;
    dpStb.wrTime  = regWr && selTime && ctrlBits[0];
    dpStb.wrCal   = regWr && selCal && ctrlBits[1];
    dpStb.wdata   = regWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlBits <= 2'b00;
      ackFlag  <= 1'b0;
      ackPend  <= 1'b0;
      secFlag  <= 1'b0;
    end else begin
      if (regWr && selSclr && regWdata[0]) ackFlag <= 1'b0;
      if (regWr && selSclr && regWdata[2]) secFlag <= 1'b0;
      if (tickSec) begin
        secFlag <= 1'b1;
        if (ackPend && anyReq) begin
          ackFlag <= 1'b1;
          ackPend <= 1'b0;
        end
      end
      if (regWr && selCtrl) begin
        ctrlBits <= regWdata[1:0];
        if (regWdata[1:0] == 2'b00) ackPend <= 1'b0;
        else if (!anyReq)           ackPend <= 1'b1;
      end
    end
  end

  always_comb begin
    regRdata = 32'h0;
    case (regAddr)
      ADDR_W'(OFS_CTRL):  regRdata = {30'h0, ctrlBits};
      ADDR_W'(OFS_MODE):  regRdata = 32'h0;
      ADDR_W'(OFS_TIME):  regRdata = timeWord;
      ADDR_W'(OFS_CAL):   regRdata = calWord;
      ADDR_W'(OFS_STAT):  regRdata = {29'h0, secFlag, 1'b0, ackFlag};
      ADDR_W'(OFS_VALID): regRdata = {30'h0, validBits};
      default:            regRdata = 32'h0;
    endcase
  end

endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobe_t   dpStb,
  output logic [31:0] timeWord,
  output logic [31:0] calWord,
  output logic [1:0]  validBits
);

  logic [31:0] timeNext;
  logic [31:0] calNext;

  always_comb begin
    logic [7:0] sB, mB, hB, cB, yB, moB, dB;
    logic [2:0] wB;
    logic       cyMin, cyHr, cyDay, cyMon, cyYr, cyCen;
    logic [7:0] sBcd, mBcd, hBcd, cBcd, yBcd, moBcd, dBcd;

    sB  = bcdToBin({1'b0, timeWord[6:0]});
    mB  = bcdToBin({1'b0, timeWord[14:8]});
    hB  = bcdToBin({2'b0, timeWord[21:16]});
    cB  = bcdToBin({1'b0, calWord[6:0]});
    yB  = bcdToBin(calWord[15:8]);
    moB = bcdToBin({3'b0, calWord[20:16]});
    dB  = bcdToBin({2'b0, calWord[29:24]});
    wB  = calWord[23:21];

    cyMin = (sB >= 8'd59);
    cyHr  = cyMin && (mB >= 8'd59);
    cyDay = cyHr && (hB >= 8'd23);
    cyMon = cyDay && (dB >= lastDay(moB, yB, cB));
    cyYr  = cyMon && (moB >= 8'd12);
    cyCen = cyYr && (yB >= 8'd99);

    sB = cyMin ? 8'd0 : sB + 8'd1;
    if (cyMin) mB = (mB >= 8'd59) ? 8'd0 : mB + 8'd1;
    if (cyHr)  hB = (hB >= 8'd23) ? 8'd0 : hB + 8'd1;
    if (cyDay) begin
      wB = (wB >= 3'd7) ? 3'd1 : wB + 3'd1;
      dB = cyMon ? 8'd1 : dB + 8'd1;
    end
    if (cyMon) moB = cyYr ? 8'd1 : moB + 8'd1;
    if (cyYr)  yB  = cyCen ? 8'd0 : yB + 8'd1;
    if (cyCen) cB  = (cB >= 8'd20) ? 8'd19 : cB + 8'd1;

    sBcd  = binToBcd(sB);
    mBcd  = binToBcd(mB);
    hBcd  = binToBcd(hB);
    cBcd  = binToBcd(cB);
    yBcd  = binToBcd(yB);
    moBcd = binToBcd(moB);
    dBcd  = binToBcd(dB);

    timeNext = {10'h0, hBcd[5:0], 1'b0, mBcd[6:0], 1'b0, sBcd[6:0]};
    calNext  = {2'b0, dBcd[5:0], wB, moBcd[4:0], yBcd, 1'b0, cBcd[6:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeWord  <= TIME_RESET;
      calWord   <= CAL_RESET;
      validBits <= 2'b00;
    end else begin
      if (dpStb.wrTime) begin
        timeWord     <= dpStb.wdata & TIME_MASK;
        validBits[0] <= !timeLegal(dpStb.wdata);
      end else if (dpStb.advance) begin
        timeWord <= timeNext;
      end
      if (dpStb.wrCal) begin
        calWord      <= dpStb.wdata & CAL_MASK;
        validBits[1] <= !calLegal(dpStb.wdata);
      end else if (dpStb.advance) begin
        calWord <= calNext;
      end
    end
  end

endmodule

// File: rtl/bcd_rtc_top.sv
module bcd_rtc_top
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickSec,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              secEvent
);

  dpStrobe_t   dpStb;
  logic [31:0] timeWord;
  logic [31:0] calWord;
  logic [1:0]  validBits;
  logic [1:0]  ctrlBits;
  logic        ackFlag;
  logic        secFlag;

  rtc_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .tickSec(tickSec),
    .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata),
    .timeWord(timeWord), .calWord(calWord), .validBits(validBits),
    .dpStb(dpStb), .regRdata(regRdata),
    .ctrlBits(ctrlBits), .ackFlag(ackFlag), .secFlag(secFlag)
  );

  rtc_datapath uDp (
    .clk(clk), .rstN(rstN), .dpStb(dpStb),
    .timeWord(timeWord), .calWord(calWord), .validBits(validBits)
  );

  assign secEvent = secFlag;

endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickSec,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWr,
  input logic [31:0]       regRdata,
  input logic [1:0]        ctrlBits,
  input logic [31:0]       timeWord,
  input logic [31:0]       calWord,
  input logic [1:0]        validBits,
  input logic              ackFlag,
  input logic              secFlag
);

  p_freeze_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBits != 2'b00) && !regWr |=> $stable(timeWord) && $stable(calWord));

  p_tick_advances_r2: assert property (@(posedge clk) disable iff (!rstN)
    tickSec && (ctrlBits == 2'b00) |=> timeWord != $past(timeWord));

  p_sec_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    tickSec |=> secFlag);

  p_ack_on_tick_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackFlag) |-> $past(tickSec) && ($past(ctrlBits) != 2'b00));

  p_locked_time_r9: assert property (@(posedge clk) disable iff (!rstN)
    regWr && (regAddr == ADDR_W'(OFS_TIME)) && !ctrlBits[0] && !tickSec
    |=> $stable(timeWord));

  p_locked_cal_r9: assert property (@(posedge clk) disable iff (!rstN)
    regWr && (regAddr == ADDR_W'(OFS_CAL)) && !ctrlBits[1] && !tickSec
    |=> $stable(calWord));

  p_bcd_digits_r2: assert property (@(posedge clk) disable iff (!rstN)
    !validBits[0] |-> (timeWord[3:0] <= 4'd9) && (timeWord[11:8] <= 4'd9)
                      && (timeWord[19:16] <= 4'd9));

  p_day_digit_r3: assert property (@(posedge clk) disable iff (!rstN)
    !validBits[1] |-> (calWord[27:24] <= 4'd9) && (calWord[29:24] != 6'd0));

  p_mode_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(OFS_MODE)) |-> (regRdata == 32'h0));

endmodule

bind bcd_rtc_top rtc_checker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .tickSec(tickSec), .regAddr(regAddr),
  .regWr(regWr), .regRdata(regRdata), .ctrlBits(ctrlBits),
  .timeWord(timeWord), .calWord(calWord), .validBits(validBits),
  .ackFlag(ackFlag), .secFlag(secFlag)
);

// File: tb/sim_bcd_rtc_top.sv
module sim_bcd_rtc_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;

  localparam logic [7:0] A_CTRL = 8'h00, A_MODE = 8'h04, A_TIME = 8'h08,
                         A_CAL = 8'h0C, A_STAT = 8'h18, A_SCLR = 8'h1C,
                         A_VALID = 8'h2C;

  typedef struct packed {
    logic [31:0] tIn;
    logic [31:0] cIn;
    logic [31:0] tExp;
    logic [31:0] cExp;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{32'h00000000, 32'h01210019, 32'h00000001, 32'h01210019, 8'd2}, // R2 seconds
    '{32'h00000059, 32'h01210019, 32'h00000100, 32'h01210019, 8'd2}, // R2 minute carry
    '{32'h00005959, 32'h01210019, 32'h00010000, 32'h01210019, 8'd2}, // R2 hour carry
    '{32'h00090959, 32'h01210019, 32'h00091000, 32'h01210019, 8'd2}, // R2 BCD digit carry
    '{32'h00195959, 32'h01210019, 32'h00200000, 32'h01210019, 8'd2}, // R2 hour digit carry
    '{32'h00235959, 32'h31610019, 32'h00000000, 32'h01820019, 8'd3}, // R3 31-day month
    '{32'h00235959, 32'h30440119, 32'h00000000, 32'h01650119, 8'd3}, // R3 30-day month
    '{32'h00235959, 32'h28E20019, 32'h00000000, 32'h01230019, 8'd4}, // R4 wrap, R3 1900
    '{32'h00235959, 32'h28420020, 32'h00000000, 32'h29620020, 8'd3}, // R3 2000 leap
    '{32'h00235959, 32'h28220419, 32'h00000000, 32'h29420419, 8'd3}, // R3 1904 leap
    '{32'h00235959, 32'h29220420, 32'h00000000, 32'h01430420, 8'd3}, // R3 Feb 29 end
    '{32'h00235959, 32'h31B29919, 32'h00000000, 32'h01C10020, 8'd5}, // R5 century
    '{32'h00235959, 32'h31929920, 32'h00000000, 32'h01A10019, 8'd5}  // R5 range wrap
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              tickSec = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic              regWr = 1'b0;
  logic [31:0]       regWdata = '0;
  logic [31:0]       regRdata;
  logic              secEvent;

  int  nRun = 0;
  int  nFail = 0;
  bit  finished = 0;

  bcd_rtc_top #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .tickSec(tickSec), .regAddr(regAddr),
    .regWr(regWr), .regWdata(regWdata), .regRdata(regRdata), .secEvent(secEvent)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdata;
  endtask

  task automatic tick();
    @(negedge clk);
    tickSec = 1'b1;
    @(negedge clk);
    tickSec = 1'b0;
  endtask

  task automatic expReg(string req, string what, logic [7:0] a, logic [31:0] exp);
    logic [31:0] v;
    rdReg(a, v);
    check(req, what, v, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    expReg("R1", "control", A_CTRL, 32'h0);
    expReg("R1", "time", A_TIME, 32'h00000000);
    expReg("R1", "calendar", A_CAL, 32'h01210019);
    expReg("R1", "status", A_STAT, 32'h0);
    expReg("R1", "validity", A_VALID, 32'h0);
    check("R1", "secEvent pin", {31'h0, secEvent}, 32'h0);

    // R9 writes without a request are ignored
    wrReg(A_TIME, 32'h00123456);
    expReg("R9", "time unlocked write", A_TIME, 32'h00000000);
    wrReg(A_CAL, 32'h15230520);
    expReg("R9", "cal unlocked write", A_CAL, 32'h01210019);

    // R8 one-second flag, R2 basic count
    tick();
    expReg("R2", "first second", A_TIME, 32'h00000001);
    expReg("R8", "status after tick", A_STAT, 32'h00000004);
    check("R8", "secEvent pin set", {31'h0, secEvent}, 32'h1);
    wrReg(A_SCLR, 32'h00000000);
    expReg("R8", "clear with zero", A_STAT, 32'h00000004);
    wrReg(A_SCLR, 32'h00000004);
    expReg("R8", "clear with one", A_STAT, 32'h00000000);

    // R7 acknowledge waits for a tick; R6 freeze
    wrReg(A_CTRL, 32'h00000001);
    expReg("R7", "no ack before tick", A_STAT, 32'h00000000);
    tick();
    expReg("R7", "ack after tick", A_STAT, 32'h00000005);
    expReg("R6", "time frozen", A_TIME, 32'h00000001);
    tick();
    expReg("R6", "time still frozen", A_TIME, 32'h00000001);
    wrReg(A_CAL, 32'h02210019);
    expReg("R9", "cal write with time request only", A_CAL, 32'h01210019);
    wrReg(A_SCLR, 32'h00000001);
    expReg("R7", "ack cleared", A_STAT, 32'h00000004);
    wrReg(A_SCLR, 32'h00000004);
    wrReg(A_CTRL, 32'h00000002);
    tick();
    expReg("R6", "cal request freezes time", A_TIME, 32'h00000001);
    expReg("R6", "cal request freezes cal", A_CAL, 32'h01210019);
    wrReg(A_CTRL, 32'h00000000);

    // Vector table: R2 R3 R4 R5
    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] v;
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      wrReg(A_CTRL, 32'h00000003);
      wrReg(A_TIME, VECS[i].tIn);
      wrReg(A_CAL, VECS[i].cIn);
      rdReg(A_VALID, v);
      check("R10", $sformatf("vector %0d legal load", i), v, 32'h0);
      wrReg(A_CTRL, 32'h00000000);
      tick();
      rdReg(A_TIME, v);
      check(tag, $sformatf("vector %0d time", i), v, VECS[i].tExp);
      rdReg(A_CAL, v);
      check(tag, $sformatf("vector %0d calendar", i), v, VECS[i].cExp);
    end

    // R10 validity flags
    wrReg(A_CTRL, 32'h00000003);
    wrReg(A_TIME, 32'h00000060);
    expReg("R10", "seconds 60", A_VALID, 32'h1);
    wrReg(A_TIME, 32'h0000005A);
    expReg("R10", "seconds digit A", A_VALID, 32'h1);
    wrReg(A_TIME, 32'h00000A00);
    expReg("R10", "minutes digit A", A_VALID, 32'h1);
    wrReg(A_TIME, 32'h00240000);
    expReg("R10", "hour 24", A_VALID, 32'h1);
    wrReg(A_TIME, 32'h00235959);
    expReg("R10", "legal time clears", A_VALID, 32'h0);
    wrReg(A_CAL, 32'h29220019);
    expReg("R10", "1900-02-29", A_VALID, 32'h2);
    wrReg(A_CAL, 32'h29220020);
    expReg("R10", "2000-02-29 legal", A_VALID, 32'h0);
    wrReg(A_CAL, 32'h31240019);
    expReg("R10", "April 31", A_VALID, 32'h2);
    wrReg(A_CAL, 32'h01330019);
    expReg("R10", "month 13", A_VALID, 32'h2);
    wrReg(A_CAL, 32'h01210021);
    expReg("R10", "century 21", A_VALID, 32'h2);
    wrReg(A_CAL, 32'h01010019);
    expReg("R10", "weekday 0", A_VALID, 32'h2);
    wrReg(A_CAL, 32'h0121001A);
    expReg("R10", "century digit A", A_VALID, 32'h2);
    wrReg(A_CAL, 32'h00210019);
    expReg("R10", "day 0", A_VALID, 32'h2);
    wrReg(A_CAL, 32'h01210019);
    expReg("R10", "legal calendar clears", A_VALID, 32'h0);
    wrReg(A_CTRL, 32'h00000000);

    // R11 mode register
    wrReg(A_MODE, 32'h00000001);
    expReg("R11", "mode reads zero", A_MODE, 32'h0);
    tick();
    expReg("R11", "24-hour count continues", A_TIME, 32'h00000000);
    expReg("R11", "date after rollover", A_CAL, 32'h02410019);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule